// File: doc/BRIEF.md
# Central-limit Gaussian noise generator

This block produces an approximately Gaussian, zero-centred stream of signed 8-bit samples, one on every clock. It runs fourteen independent 18-bit linear feedback shift registers. Each one moves four steps per clock and supplies a fresh 4-bit uniform value. A fully pipelined binary adder tree sums these values. By the Central Limit Theorem, the sum of many uniform values tends towards a bell-shaped distribution. A receiver or correlator datapath can use the block as a stimulus when no real input is connected.

A 3-bit run-time select chooses how many uniform values reach the output: one, two, four, eight or all fourteen. Stepping through the select shows the distribution change from flat towards Gaussian. A fixed offset of 105 is subtracted from the chosen sum. That offset is half the largest possible fourteen-way sum, so the full sum is centred on zero. A synchronous reset reloads every generator from its fixed seed, and the stream then repeats exactly.

Top module: `clt_noise_gen`

## Requirements
- R1: Generator k (k = 0..13) holds an 18-bit state s. One step maps s to {s[16:0], s[17] ^ s[10]}. The state takes four steps per clock. The generator's uniform value in a cycle is s[3:0] of its current state, read as unsigned.
- R2: While reset is high at a rising edge, generator k loads seed bits [24:7] of the 32-bit wrapped product (k+1) * 0x9E3779B1, or 1 if those bits are zero. Its state is never all-zero afterwards.
- R3: The select code picks which values are summed. Code 0 takes generator 0 alone. Code 1 takes generators 0 and 1. Code 2 takes generators 0 to 3. Code 3 takes generators 0 to 7. Codes 4 to 7 take all fourteen.
- R4: The output is the chosen sum minus 105, written as an 8-bit two's complement value.
- R5: The uniform values consumed at rising edge j reach the output just after edge j+4 for every select code. A select value sampled at edge j applies to the output just after edge j+1.
- R6: With all fourteen summed, every output lies in -105..+105 without wrap-around. Over a long run the mean of the outputs is within 2 of zero.
- R7: While reset is high at a rising edge, the output becomes 0 and the pipeline is cleared. After release, the same output sequence is produced for the same select history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset; reloads seeds and clears the pipeline |
| sel | input | 3 | Number-of-sources select code |
| sample | output | 8 | Signed, zero-centred noise sample |

## Verification
Assertions check on every cycle that the fourteen-way output never leaves its ±105 span. They also check that the select strobe is always one-hot, that codes above four clamp to the full sum, and that no generator state is ever zero after reseeding. A further assertion checks that the delay-matched taps stay ordered, so a wider partial sum is never smaller than a narrower one from the same cycle. Only the bench's scenarios can show that each output equals the offset sum of exactly the right generators at exactly the right latency, and that the values follow the stated recurrence and seeds. Only the bench can also show that a mid-run reset replays the stream, and that the long-run mean settles near zero.

// File: rtl/clt_noise_pkg.sv
package clt_noise_pkg;

  localparam int GEN_COUNT     = 14;
  localparam int LFSR_LEN      = 18;
  localparam int FB_TAP_HI     = 17;
  localparam int FB_TAP_LO     = 10;
  localparam int NIB_W         = 4;
  localparam int TREE_LEVELS   = $clog2(GEN_COUNT);
  localparam int TREE_PAD      = 1 << TREE_LEVELS;
  localparam int SUM_W         = NIB_W + TREE_LEVELS;
  localparam int OUT_W         = SUM_W;
  localparam int SEL_W         = $clog2(TREE_LEVELS + 1);
  localparam int CENTRE_OFFSET = (GEN_COUNT * ((1 << NIB_W) - 1)) / 2;

  // One strobe per tree tap; exactly one is set.
  typedef struct packed {
    logic [TREE_LEVELS:0] tapSel;
  } tap_strobe_t;

  // Seed derivation: a golden-ratio multiplicative hash of the index.
  function automatic logic [LFSR_LEN-1:0] seedFor(input int idx);
    logic [31:0] mix;
    logic [LFSR_LEN-1:0] s;
    mix = 32'(idx + 1) * 32'h9E37_79B1;
    s   = mix[LFSR_LEN+6:7];
    if (s == '0) s = 1;
    return s;
  endfunction

endpackage

// File: rtl/clt_noise_lfsr.sv
module clt_noise_lfsr
  import clt_noise_pkg::*;
#(
  parameter logic [LFSR_LEN-1:0] SEED = 1
) (
  input  logic             clk,
  input  logic             rst,
  output logic [NIB_W-1:0] nibble
);

  logic [LFSR_LEN-1:0] stateQ;
  logic [LFSR_LEN-1:0] leapD;

  // Look ahead NIB_W serial steps in one clock.
  always_comb begin
    leapD = stateQ;
    for (int k = 0; k < NIB_W; k++) begin
      leapD = {leapD[LFSR_LEN-2:0], leapD[FB_TAP_HI] ^ leapD[FB_TAP_LO]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= SEED;
    else     stateQ <= leapD;
  end

  assign nibble = stateQ[NIB_W-1:0];

  // R2: reseed on reset
  assert_reseed_R2: assert property (@(posedge clk) rst |=> (stateQ == SEED));

  // R2: a maximal-length register never falls into the all-zero lock state
  assert_state_live_R2: assert property (@(posedge clk) disable iff (rst)
    stateQ != '0);

endmodule

// File: rtl/clt_noise_ctrl.sv
module clt_noise_ctrl
  import clt_noise_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  output tap_strobe_t      strb
);

  logic [SEL_W-1:0] selEff;
  tap_strobe_t      strbD;

  // Codes beyond the deepest tap clamp to the full sum.
  assign selEff = (sel > SEL_W'(TREE_LEVELS)) ? SEL_W'(TREE_LEVELS) : sel;

  always_comb begin
    for (int l = 0; l <= TREE_LEVELS; l++) begin
      strbD.tapSel[l] = (selEff == SEL_W'(l));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) strb.tapSel <= (TREE_LEVELS + 1)'(1);
    else     strb <= strbD;
  end

  // R3: exactly one tap is ever chosen
  assert_strobe_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    $countones(strb.tapSel) == 1);

  // R3: large codes select the full fourteen-way sum on the next cycle
  assert_sel_clamp_R3: assert property (@(posedge clk) disable iff (rst)
    (sel >= SEL_W'(TREE_LEVELS)) |=> strb.tapSel[TREE_LEVELS]);

endmodule

// File: rtl/clt_noise_sum.sv
module clt_noise_sum
  import clt_noise_pkg::*;
(
  input  logic                              clk,
  input  logic                              rst,
  input  logic [GEN_COUNT-1:0][NIB_W-1:0]   nibbles,
  input  tap_strobe_t                       strb,
  output logic signed [OUT_W-1:0]           sample
);

  localparam int HALF = TREE_PAD / 2;

  logic [SUM_W-1:0] leaf [TREE_PAD];
  logic [SUM_W-1:0] node [1:TREE_LEVELS][HALF];
  logic [TREE_LEVELS:0][SUM_W-1:0] tapSrc;
  logic [TREE_LEVELS:0][SUM_W-1:0] tapAligned;
  logic [SUM_W-1:0] picked;
  logic signed [SUM_W:0] centred;

  // Leaves: real generators, then zero padding up to a power of two.
  for (genvar n = 0; n < GEN_COUNT; n++) begin : g_leaf
    assign leaf[n] = SUM_W'(nibbles[n]);
  end
  for (genvar n = GEN_COUNT; n < TREE_PAD; n++) begin : g_pad
    assign leaf[n] = '0;
  end

  // Registered adder tree, one level per clock.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int l = 1; l <= TREE_LEVELS; l++) begin
        for (int n = 0; n < HALF; n++) node[l][n] <= '0;
      end
    end else begin
      for (int n = 0; n < HALF; n++) begin
        node[1][n] <= leaf[2*n] + leaf[2*n+1];
      end
      for (int l = 2; l <= TREE_LEVELS; l++) begin
        for (int n = 0; n < (TREE_PAD >> l); n++) begin
          node[l][n] <= node[l-1][2*n] + node[l-1][2*n+1];
        end
      end
    end
  end

  // Tap l is the sum of the first 2**l generators (all of them at the root).
  assign tapSrc[0] = leaf[0];
  for (genvar l = 1; l <= TREE_LEVELS; l++) begin : g_tap
    assign tapSrc[l] = node[l][0];
  end

  // Delay shallow taps so every tap is TREE_LEVELS clocks behind its leaves.
  for (genvar l = 0; l <= TREE_LEVELS; l++) begin : g_align
    localparam int DEPTH = TREE_LEVELS - l;
    if (DEPTH == 0) begin : g_direct
      assign tapAligned[l] = tapSrc[l];
    end else begin : g_pipe
      logic [SUM_W-1:0] pipe [DEPTH];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int d = 0; d < DEPTH; d++) pipe[d] <= '0;
        end else begin
          pipe[0] <= tapSrc[l];
          for (int d = 1; d < DEPTH; d++) pipe[d] <= pipe[d-1];
        end
      end
      assign tapAligned[l] = pipe[DEPTH-1];
    end
  end

  // One-hot AND-OR selection of the aligned tap.
  always_comb begin
    picked = '0;
    for (int l = 0; l <= TREE_LEVELS; l++) begin
      if (strb.tapSel[l]) picked = picked | tapAligned[l];
    end
  end

  assign centred = $signed({1'b0, picked}) - $signed((SUM_W + 1)'(CENTRE_OFFSET));

  always_ff @(posedge clk) begin
    if (rst) sample <= '0;
    else     sample <= centred[OUT_W-1:0];
  end

  // R6: output never leaves the symmetric span around zero
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    (sample <= CENTRE_OFFSET) && (sample >= -CENTRE_OFFSET));

  // R7: reset clears the output register
  assert_reset_out_R7: assert property (@(posedge clk) rst |=> (sample == '0));

  // R5: taps aligned to the same leaf cycle are ordered by width
  for (genvar l = 1; l <= TREE_LEVELS; l++) begin : g_order_chk
    assert_tap_order_R5: assert property (@(posedge clk) disable iff (rst)
      tapAligned[l] >= tapAligned[l-1]);
  end

endmodule

// File: rtl/clt_noise_gen.sv
module clt_noise_gen
  import clt_noise_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic [SEL_W-1:0]        sel,
  output logic signed [OUT_W-1:0] sample
);

  logic [GEN_COUNT-1:0][NIB_W-1:0] genNibble;
  tap_strobe_t                     tapStrb;

  for (genvar g = 0; g < GEN_COUNT; g++) begin : g_src
    clt_noise_lfsr #(.SEED(seedFor(g))) u_lfsr (
      .clk    (clk),
      .rst    (rst),
      .nibble (genNibble[g])
    );
  end

  clt_noise_ctrl u_ctrl (
    .clk  (clk),
    .rst  (rst),
    .sel  (sel),
    .strb (tapStrb)
  );

  clt_noise_sum u_sum (
    .clk     (clk),
    .rst     (rst),
    .nibbles (genNibble),
    .strb    (tapStrb),
    .sample  (sample)
  );

endmodule

// File: tb/clt_noise_gen_tb.sv
module clt_noise_gen_tb;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [2:0]        sel = 3'd0;
  logic signed [7:0] sample;

  always #5 clk = ~clk;

  clt_noise_gen u_dut (
    .clk    (clk),
    .rst    (rst),
    .sel    (sel),
    .sample (sample)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  logic [17:0] mdl [14];
  int  entries   = 0;
  bit  rstAtEdge = 1'b0;
  int  tapHist [8][5];
  int  selHist [8];

  bit  statsOn = 1'b0;
  int  statSum = 0;
  int  statCnt = 0;
  int  statMin = 1000;
  int  statMax = -1000;

  // R2 seed formula
  function automatic logic [17:0] benchSeed(input int k);
    logic [31:0] p;
    p = 32'(k + 1) * 32'h9E37_79B1;
    if (p[24:7] == 18'd0) return 18'd1;
    return p[24:7];
  endfunction

  // R1 single serial step
  function automatic logic [17:0] serialStep(input logic [17:0] s);
    return {s[16:0], s[17] ^ s[10]};
  endfunction

  // R3 code map
  function automatic int codeToTap(input int c);
    return (c > 4) ? 4 : c;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Reference model: advances at each edge, records what the edge consumes.
  always @(posedge clk) begin
    if (rst) begin
      for (int g = 0; g < 14; g++) mdl[g] = benchSeed(g);
      entries   = 0;
      rstAtEdge = 1'b1;
    end else begin
      int acc;
      int slot;
      rstAtEdge = 1'b0;
      slot = entries % 8;
      acc = 0;
      for (int g = 0; g < 14; g++) begin
        acc += int'(mdl[g][3:0]);
        if (g == 0)  tapHist[slot][0] = acc;
        if (g == 1)  tapHist[slot][1] = acc;
        if (g == 3)  tapHist[slot][2] = acc;
        if (g == 7)  tapHist[slot][3] = acc;
        if (g == 13) tapHist[slot][4] = acc;
      end
      selHist[slot] = int'(sel);
      for (int g = 0; g < 14; g++) begin
        for (int st = 0; st < 4; st++) mdl[g] = serialStep(mdl[g]);
      end
      entries++;
    end
  end

  // Compare away from the active edge.
  always @(negedge clk) begin
    if (!done) begin
      if (rstAtEdge) begin
        check("R7 reset output", int'(sample), 0);
      end else if (entries >= 5) begin
        int m;
        int expv;
        m = entries - 1;
        // R1 R3 R4 R5: value consumed 4 edges ago, select from 1 edge ago
        expv = tapHist[(m - 4) % 8][codeToTap(selHist[(m - 1) % 8])] - 105;
        check("R1/R3/R4/R5 sample", int'(sample), expv);
        if (statsOn) begin
          statSum += int'(sample);
          statCnt++;
          if (int'(sample) < statMin) statMin = int'(sample);
          if (int'(sample) > statMax) statMax = int'(sample);
        end
      end
    end
  end

  initial begin
    void'($urandom(32'd31415));
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // Directed: every select code held, including clamped codes 5..7 (R3)
    for (int c = 0; c < 8; c++) begin
      sel = 3'(c);
      repeat (20) @(negedge clk);
    end

    // Random select changes on every cycle exercise R5 select latency
    repeat (600) begin
      @(negedge clk);
      sel = 3'($urandom_range(0, 7));
    end

    // Mid-run reset: stream must restart from the seeds (R2, R7)
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    sel = 3'd4;
    repeat (10) @(negedge clk);

    // Long fourteen-way run for range and mean (R6)
    statsOn = 1'b1;
    repeat (4000) @(negedge clk);
    statsOn = 1'b0;

    check("R6 maximum within +105", (statMax <= 105) ? 1 : 0, 1);
    check("R6 minimum within -105", (statMin >= -105) ? 1 : 0, 1);
    check("R6 mean near zero", ((statSum <= 2 * statCnt) && (statSum >= -2 * statCnt)) ? 1 : 0, 1);

    sel = 3'd7;
    repeat (8) @(negedge clk);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule